// File: doc/BRIEF.md
# Tagged Fully-Associative Translation Cache

This block caches recent page translations for a processor's memory unit. Each of its entries pairs a virtual page number and an address-space tag with a physical page number, four access-right bits, a cacheable attribute and reference/modify history bits. A lookup arrives with a virtual address, a read/write flag, the privilege level and the tag of the running address space. In the same cycle the block answers with exactly one of hit, miss or protection fault, and on a hit it gives the physical address.

Software or a table walker installs translations through a refill port. When every entry is occupied, a tree pseudo-LRU picks the entry to replace. A control port removes one translation, which software uses after it edits a page-table entry. It can also flush the whole array. Tag matching can be turned off. In that case a context switch needs a flush; with tags on, only the current tag input changes.

Top module: `tlb_tagged`

## Requirements
- R1: A lookup hits when an entry is valid, its VPN equals vaddr[31:12], its tag equals asid_i (only when tag_en_i is 1), and its rights allow the access. In the same cycle, lk_paddr_o = {stored PPN, vaddr[11:0]} and lk_cacheable_o gives the entry's cacheable bit.
- R2: When no valid entry matches, a lookup reports miss with hit and fault low. After reset, or for an entry that has been invalidated, every lookup misses. With lk_valid_i high, exactly one of hit, miss and fault is high.
- R3: The rights field is 4 bits: bit 0 user read, bit 1 user write, bit 2 kernel read, bit 3 kernel write. A matching entry whose bit for the current mode and access type is clear gives a fault, not a miss, and leaves its reference and modify bits unchanged.
- R4: The reference bit is set on every hit, and the modify bit is set on every write hit. lk_ref_o and lk_mod_o show the matched entry's bits as they stood before this access. A refill clears both bits.
- R5: With tag_en_i=1, an entry holding another tag does not match. With tag_en_i=0, tags are ignored. If several entries match, the lowest index is used.
- R6: An invalidate clears every entry that matches (inv_asid_i, inv_vpn_i) under the same tag rule. The change is visible from the next cycle.
- R7: A flush clears all entries in one cycle. A refill or invalidate in the same cycle is discarded.
- R8: A refill overwrites the entry that already matches its (tag, VPN). Otherwise it takes the lowest-index invalid entry. Otherwise it takes the tree pseudo-LRU victim. Hits and refills mark their entry most recently used, and a refill takes precedence over a hit when both occur in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tag_en_i | input | 1 | Enable tag comparison |
| asid_i | input | 8 | Tag of the running address space |
| lk_valid_i | input | 1 | Lookup request |
| lk_vaddr_i | input | 32 | Virtual address |
| lk_write_i | input | 1 | 1 = write access |
| lk_user_i | input | 1 | 1 = user mode, 0 = kernel |
| lk_hit_o | output | 1 | Lookup hit |
| lk_miss_o | output | 1 | No matching entry |
| lk_fault_o | output | 1 | Match but access not permitted |
| lk_paddr_o | output | 32 | Physical address |
| lk_cacheable_o | output | 1 | Cacheable bit of matched entry |
| lk_ref_o | output | 1 | Reference bit of matched entry |
| lk_mod_o | output | 1 | Modify bit of matched entry |
| fill_valid_i | input | 1 | Refill request |
| fill_vpn_i | input | 20 | Refill VPN |
| fill_asid_i | input | 8 | Refill tag |
| fill_ppn_i | input | 20 | Refill PPN |
| fill_perm_i | input | 4 | Refill rights |
| fill_cacheable_i | input | 1 | Refill cacheable bit |
| inv_i | input | 1 | Invalidate request |
| inv_vpn_i | input | 20 | VPN to invalidate |
| inv_asid_i | input | 8 | Tag to invalidate |
| flush_i | input | 1 | Clear all entries |

## Verification
On every cycle the assertions check the following. Hit, miss and fault are mutually exclusive. A flush empties the array. An invalidate leaves no matching entry valid. A hit leaves the reference bit set, and a write hit leaves the modify bit set. A refill always leaves some entry valid. The replacement order, how tags act when switched on and off, the rights decoding for each mode, and the discarding of a refill that coincides with a flush can only be shown by the bench. It checks these with directed sequences and with a long random run compared against a reference model of entries and tree bits.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned PERM_W = 4;
  // rights index = {kernel, write}
  function automatic logic perm_ok(logic [PERM_W-1:0] perm, logic user, logic wr);
    return perm[{~user, wr}];
  endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int unsigned N  = 8,
  parameter int unsigned VW = 20,
  parameter int unsigned TW = 8
) (
  input  logic [N-1:0]         valid_i,
  input  logic [N-1:0][VW-1:0] vpn_i,
  input  logic [N-1:0][TW-1:0] tag_i,
  input  logic                 tag_en_i,
  input  logic [VW-1:0]        key_vpn_i,
  input  logic [TW-1:0]        key_tag_i,
  output logic [N-1:0]         match_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (vpn_i[g] == key_vpn_i) &&
                        (!tag_en_i || (tag_i[g] == key_tag_i));
  end
endmodule

// File: rtl/tlb_plru.sv
module tlb_plru #(
  parameter int unsigned N  = 8,
  localparam int unsigned LW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          touch_i,
  input  logic [LW-1:0] touch_idx_i,
  output logic [LW-1:0] victim_o
);
  // heap-ordered nodes 1..N-1; bit=1 points the victim search right
  logic [N-1:1] tree_q, tree_d;

  always_comb begin
    tree_d = tree_q;
    if (touch_i) begin
      for (int lvl = 0; lvl < LW; lvl++) begin
        tree_d[(1 << lvl) + (int'(touch_idx_i) >> (LW - lvl))] = ~touch_idx_i[LW-1-lvl];
      end
    end
  end

  always_comb begin
    int n;
    n = 1;
    for (int lvl = 0; lvl < LW; lvl++) n = 2 * n + int'(tree_q[n]);
    victim_o = LW'(n - int'(N));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tree_q <= '0;
    else         tree_q <= tree_d;
  end

  // R8: a touched entry is never the next victim
  a_r8_touch_not_victim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> (victim_o != $past(touch_idx_i)));
endmodule

// File: rtl/tlb_tagged.sv
module tlb_tagged #(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned VPN_W     = 20,
  parameter int unsigned PPN_W     = 20,
  parameter int unsigned ASID_W    = 8,
  parameter int unsigned OFF_W     = 12,
  localparam int unsigned VA_W = VPN_W + OFF_W,
  localparam int unsigned PA_W = PPN_W + OFF_W,
  localparam int unsigned LW   = $clog2(N_ENTRIES),
  localparam int unsigned PW   = tlb_pkg::PERM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tag_en_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              lk_valid_i,
  input  logic [VA_W-1:0]   lk_vaddr_i,
  input  logic              lk_write_i,
  input  logic              lk_user_i,
  output logic              lk_hit_o,
  output logic              lk_miss_o,
  output logic              lk_fault_o,
  output logic [PA_W-1:0]   lk_paddr_o,
  output logic              lk_cacheable_o,
  output logic              lk_ref_o,
  output logic              lk_mod_o,
  input  logic              fill_valid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [PPN_W-1:0]  fill_ppn_i,
  input  logic [PW-1:0]     fill_perm_i,
  input  logic              fill_cacheable_i,
  input  logic              inv_i,
  input  logic [VPN_W-1:0]  inv_vpn_i,
  input  logic [ASID_W-1:0] inv_asid_i,
  input  logic              flush_i
);
  localparam int unsigned N = N_ENTRIES;

  logic [N-1:0]             valid_q, ref_q, mod_q, cach_q;
  logic [N-1:0][VPN_W-1:0]  vpn_q;
  logic [N-1:0][ASID_W-1:0] asid_q;
  logic [N-1:0][PPN_W-1:0]  ppn_q;
  logic [N-1:0][PW-1:0]     perm_q;

  logic [N-1:0]  lk_match, inv_match, fill_match;
  logic [LW-1:0] lk_idx, dup_idx, free_idx, victim, fill_idx, touch_idx;
  logic          lk_any, lk_allow, lk_hit, touch;

  tlb_cam #(.N(N), .VW(VPN_W), .TW(ASID_W)) u_cam_lk (
    .valid_i(valid_q), .vpn_i(vpn_q), .tag_i(asid_q), .tag_en_i(tag_en_i),
    .key_vpn_i(lk_vaddr_i[VA_W-1:OFF_W]), .key_tag_i(asid_i), .match_o(lk_match));
  tlb_cam #(.N(N), .VW(VPN_W), .TW(ASID_W)) u_cam_inv (
    .valid_i(valid_q), .vpn_i(vpn_q), .tag_i(asid_q), .tag_en_i(tag_en_i),
    .key_vpn_i(inv_vpn_i), .key_tag_i(inv_asid_i), .match_o(inv_match));
  tlb_cam #(.N(N), .VW(VPN_W), .TW(ASID_W)) u_cam_fill (
    .valid_i(valid_q), .vpn_i(vpn_q), .tag_i(asid_q), .tag_en_i(tag_en_i),
    .key_vpn_i(fill_vpn_i), .key_tag_i(fill_asid_i), .match_o(fill_match));

  // lowest index wins for every encoder
  always_comb begin
    lk_idx = '0; dup_idx = '0; free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (lk_match[i])   lk_idx   = LW'(i);
      if (fill_match[i]) dup_idx  = LW'(i);
      if (!valid_q[i])   free_idx = LW'(i);
    end
  end

  tlb_plru #(.N(N)) u_plru (
    .clk_i(clk_i), .rst_ni(rst_ni), .touch_i(touch),
    .touch_idx_i(touch_idx), .victim_o(victim));

  always_comb begin
    if (|fill_match)    fill_idx = dup_idx;
    else if (!(&valid_q)) fill_idx = free_idx;
    else                fill_idx = victim;
  end

  assign lk_any   = lk_valid_i && (|lk_match);
  assign lk_allow = tlb_pkg::perm_ok(perm_q[lk_idx], lk_user_i, lk_write_i);
  assign lk_hit   = lk_any && lk_allow;

  assign lk_hit_o       = lk_hit;
  assign lk_fault_o     = lk_any && !lk_allow;
  assign lk_miss_o      = lk_valid_i && !(|lk_match);
  assign lk_paddr_o     = lk_hit ? {ppn_q[lk_idx], lk_vaddr_i[OFF_W-1:0]} : '0;
  assign lk_cacheable_o = lk_any && cach_q[lk_idx];
  assign lk_ref_o       = lk_any && ref_q[lk_idx];
  assign lk_mod_o       = lk_any && mod_q[lk_idx];

  assign touch     = !flush_i && (fill_valid_i || lk_hit);
  assign touch_idx = fill_valid_i ? fill_idx : lk_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0; ref_q <= '0; mod_q <= '0; cach_q <= '0;
      vpn_q <= '0; asid_q <= '0; ppn_q <= '0; perm_q <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
    end else begin
      if (inv_i) valid_q <= valid_q & ~inv_match;
      if (lk_hit) begin
        ref_q[lk_idx] <= 1'b1;
        if (lk_write_i) mod_q[lk_idx] <= 1'b1;
      end
      // refill applied last so it overrides a same-slot hit or invalidate
      if (fill_valid_i) begin
        valid_q[fill_idx] <= 1'b1;
        vpn_q[fill_idx]   <= fill_vpn_i;
        asid_q[fill_idx]  <= fill_asid_i;
        ppn_q[fill_idx]   <= fill_ppn_i;
        perm_q[fill_idx]  <= fill_perm_i;
        cach_q[fill_idx]  <= fill_cacheable_i;
        ref_q[fill_idx]   <= 1'b0;
        mod_q[fill_idx]   <= 1'b0;
      end
    end
  end

  a_r2_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |-> ($countones({lk_hit_o, lk_miss_o, lk_fault_o}) == 1));
  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |-> !(lk_hit_o || lk_miss_o || lk_fault_o));
  a_r7_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0));
  a_r6_inv_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_i && !fill_valid_i) |=> ((valid_q & $past(inv_match)) == '0));
  a_r4_ref_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_hit_o && !flush_i && !fill_valid_i) |=> ref_q[$past(lk_idx)]);
  a_r4_mod_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_hit_o && lk_write_i && !flush_i && !fill_valid_i) |=> mod_q[$past(lk_idx)]);
  a_r8_fill_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !flush_i) |=> (valid_q != '0));
endmodule

// File: tb/tlb_tagged_bench.sv
module tlb_tagged_bench;
  logic clk = 1'b0, rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic tag_en, lk_v, lk_w, lk_u, fill_v, fill_c, inv, flush;
  logic [7:0] asid, fill_asid, inv_asid;
  logic [31:0] va;
  logic [19:0] fill_vpn, fill_ppn, inv_vpn;
  logic [3:0] fill_perm;
  logic hit, miss, fault, cach, rf, md;
  logic [31:0] pa;

  tlb_tagged u_tlb_tagged (
    .clk_i(clk), .rst_ni(rst_ni), .tag_en_i(tag_en), .asid_i(asid),
    .lk_valid_i(lk_v), .lk_vaddr_i(va), .lk_write_i(lk_w), .lk_user_i(lk_u),
    .lk_hit_o(hit), .lk_miss_o(miss), .lk_fault_o(fault), .lk_paddr_o(pa),
    .lk_cacheable_o(cach), .lk_ref_o(rf), .lk_mod_o(md),
    .fill_valid_i(fill_v), .fill_vpn_i(fill_vpn), .fill_asid_i(fill_asid),
    .fill_ppn_i(fill_ppn), .fill_perm_i(fill_perm), .fill_cacheable_i(fill_c),
    .inv_i(inv), .inv_vpn_i(inv_vpn), .inv_asid_i(inv_asid), .flush_i(flush));

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model
  logic       m_v[8], m_r[8], m_m[8], m_c[8];
  logic [19:0] m_vpn[8], m_ppn[8];
  logic [7:0]  m_tag[8];
  logic [3:0]  m_perm[8];
  logic        t[1:7];

  function automatic int find(logic [19:0] vpn, logic [7:0] tg);
    for (int i = 0; i < 8; i++)
      if (m_v[i] && m_vpn[i] == vpn && (!tag_en || m_tag[i] == tg)) return i;
    return -1;
  endfunction

  function automatic int victim_of();
    int n = 1;
    for (int l = 0; l < 3; l++) n = 2 * n + int'(t[n]);
    return n - 8;
  endfunction

  function automatic void touch_m(int i);
    t[1] = ~i[2];
    t[2 + i[2]] = ~i[1];
    t[4 + 2 * i[2] + i[1]] = ~i[0];
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    lk_v = 0; fill_v = 0; inv = 0; flush = 0; lk_w = 0; lk_u = 0; fill_c = 0;
    va = '0; fill_vpn = '0; fill_ppn = '0; fill_perm = '0; fill_asid = '0;
    inv_vpn = '0; inv_asid = '0;
  endtask

  // drives stimulus already set on the signals, checks lookup, updates model
  task automatic step(string req);
    int li, fi, perm_i;
    logic ehit, efault, emiss;
    #5;
    li = lk_v ? find(va[31:12], asid) : -1;
    perm_i = {~lk_u, lk_w};
    ehit = 0; efault = 0; emiss = 0;
    if (lk_v) begin
      emiss  = (li < 0);
      ehit   = (li >= 0) && m_perm[li][perm_i];
      efault = (li >= 0) && !m_perm[li][perm_i];
      chk(req, "hit", 32'(hit), 32'(ehit));
      chk(req, "miss", 32'(miss), 32'(emiss));
      chk(req, "fault", 32'(fault), 32'(efault));
      if (ehit) chk(req, "paddr", pa, {m_ppn[li], va[11:0]});
      if (li >= 0) begin
        chk(req, "ref", 32'(rf), 32'(m_r[li]));
        chk(req, "mod", 32'(md), 32'(m_m[li]));
        chk(req, "cacheable", 32'(cach), 32'(m_c[li]));
      end
    end
    // model update at the coming edge
    fi = -1;
    if (fill_v) begin
      fi = find(fill_vpn, fill_asid);
      if (fi < 0) for (int i = 7; i >= 0; i--) if (!m_v[i]) fi = i;
      if (fi < 0) fi = victim_of();
    end
    if (flush) begin
      for (int i = 0; i < 8; i++) m_v[i] = 0;
    end else begin
      if (inv) for (int i = 0; i < 8; i++)
        if (m_v[i] && m_vpn[i] == inv_vpn && (!tag_en || m_tag[i] == inv_asid)) m_v[i] = 0;
      if (ehit) begin m_r[li] = 1; if (lk_w) m_m[li] = 1; end
      if (fill_v) begin
        m_v[fi] = 1; m_vpn[fi] = fill_vpn; m_tag[fi] = fill_asid; m_ppn[fi] = fill_ppn;
        m_perm[fi] = fill_perm; m_c[fi] = fill_c; m_r[fi] = 0; m_m[fi] = 0;
        touch_m(fi);
      end else if (ehit) touch_m(li);
    end
    @(negedge clk);
    idle();
  endtask

  task automatic look(logic [19:0] vpn, logic [7:0] a, logic w, logic u, string req);
    lk_v = 1; va = {vpn, 12'h3a5}; asid = a; lk_w = w; lk_u = u;
    step(req);
  endtask

  task automatic fill(logic [19:0] vpn, logic [7:0] a, logic [19:0] ppn, logic [3:0] p, logic c);
    fill_v = 1; fill_vpn = vpn; fill_asid = a; fill_ppn = ppn; fill_perm = p; fill_c = c;
    step("R8");
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) begin
      m_v[i] = 0; m_r[i] = 0; m_m[i] = 0; m_c[i] = 0;
      m_vpn[i] = 0; m_ppn[i] = 0; m_tag[i] = 0; m_perm[i] = 0;
    end
    for (int i = 1; i < 8; i++) t[i] = 0;
    idle(); tag_en = 1; asid = 8'd1;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R2: empty after reset
    look(20'h00111, 8'd1, 0, 1, "R2");
    chk("R2", "reset miss", 32'(miss), 32'd1);

    // R1, R4: hit, address, reference then modify
    fill(20'h00111, 8'd1, 20'hABCDE, 4'b0011, 1'b1);
    look(20'h00111, 8'd1, 0, 1, "R1");
    look(20'h00111, 8'd1, 1, 1, "R4");
    look(20'h00111, 8'd1, 0, 1, "R4");
    #0 chk("R4", "ref after hits", 32'(m_r[0]), 32'd1);

    // R3: rights
    fill(20'h00222, 8'd1, 20'h12345, 4'b0001, 1'b0);   // user read only
    look(20'h00222, 8'd1, 1, 1, "R3");                   // user write -> fault
    look(20'h00222, 8'd1, 0, 0, "R3");                   // kernel read -> fault
    fill(20'h00333, 8'd1, 20'h0F0F0, 4'b1100, 1'b0);   // kernel only
    look(20'h00333, 8'd1, 1, 0, "R3");
    look(20'h00333, 8'd1, 0, 1, "R3");
    look(20'h00222, 8'd1, 0, 1, "R3");                   // ref stayed clear after faults

    // R5: tags
    look(20'h00111, 8'd2, 0, 1, "R5");
    tag_en = 0;
    look(20'h00111, 8'd2, 0, 1, "R5");
    tag_en = 1;

    // R6: invalidate
    inv = 1; inv_vpn = 20'h00111; inv_asid = 8'd1; step("R6");
    look(20'h00111, 8'd1, 0, 1, "R6");
    chk("R6", "after invalidate", 32'(miss), 32'd1);

    // R7: flush, and flush discards a same-cycle refill
    flush = 1; fill_v = 1; fill_vpn = 20'h00999; fill_asid = 8'd1; fill_perm = 4'hF;
    step("R7");
    look(20'h00222, 8'd1, 0, 1, "R7");
    look(20'h00999, 8'd1, 0, 1, "R7");
    chk("R7", "flush+fill", 32'(miss), 32'd1);

    // R8: fill all eight, next refill evicts entry 0
    for (int i = 0; i < 8; i++) fill(20'h00400 + 20'(i), 8'd1, 20'h00500 + 20'(i), 4'hF, 1'b0);
    look(20'h00400, 8'd1, 0, 1, "R8");                   // touch 0, victim becomes 4
    fill(20'h00777, 8'd1, 20'h07777, 4'hF, 1'b1);
    look(20'h00404, 8'd1, 0, 1, "R8");
    chk("R8", "plru evicted slot 4", 32'(miss), 32'd1);
    look(20'h00400, 8'd1, 0, 1, "R8");
    chk("R8", "recent entry kept", 32'(hit), 32'd1);
    fill(20'h00401, 8'd1, 20'h0AAAA, 4'hF, 1'b0);      // overwrite existing
    look(20'h00401, 8'd1, 0, 1, "R8");
    chk("R8", "overwrite paddr", pa, 32'h0AAAA3A5);

    // random mix against the model
    for (int k = 0; k < 4000; k++) begin
      int op;
      op = int'($urandom_range(0, 99));
      tag_en = ($urandom_range(0, 9) != 0);
      if (op < 55) begin
        look(20'h00600 + 20'($urandom_range(0, 9)), 8'($urandom_range(1, 3)),
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R1");
      end else if (op < 85) begin
        fill_v = 1; fill_vpn = 20'h00600 + 20'($urandom_range(0, 9));
        fill_asid = 8'($urandom_range(1, 3)); fill_ppn = 20'($urandom);
        fill_perm = 4'($urandom); fill_c = 1'($urandom_range(0, 1));
        lk_v = ($urandom_range(0, 1) == 1); va = {20'h00600 + 20'($urandom_range(0, 9)), 12'h010};
        asid = 8'($urandom_range(1, 3)); lk_u = 1'($urandom_range(0, 1)); lk_w = 1'($urandom_range(0, 1));
        step("R8");
      end else if (op < 97) begin
        inv = 1; inv_vpn = 20'h00600 + 20'($urandom_range(0, 9)); inv_asid = 8'($urandom_range(1, 3));
        step("R6");
      end else begin
        flush = 1; step("R7");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule